// File: doc/BRIEF.md
# Strap-Selectable-Edge Serial Control Slave

This block is the serial programming port of a six-channel output switch controller. An external master lowers an active-low select and clocks one 16-bit word into the block, most significant bit first. The block checks that the word is exactly 16 bits long and decodes the top four bits as a command. It updates the matching configuration register once select returns high. In the same frame it shifts a diagnostic word back out, built from two status bits per channel.

A static strap input picks the serial clock edge used for receiving. When the strap is low, data in is sampled on rising serial clock edges and data out moves on falling edges. When the strap is high the two edges swap. All serial inputs are brought into the system clock domain through synchronizers, and edges are detected there. The data-out pin is modelled as a value plus an output enable.

Top module: `sps_serial_slave`

## Requirements
- R1: After reset, `ch_on`, `and_mask` and `low_side` are all zero and `so_oe` is low.
- R2: A frame carries 16 bits, most significant bit first. Bits 15:12 hold the command code and bits 11:0 hold the data. Configuration registers change only after select rises.
- R3: With `edge_sel` low, `si` is sampled on rising `sclk` edges and `so_d` advances on falling edges.
- R4: With `edge_sel` high, `si` is sampled on falling `sclk` edges and `so_d` advances on rising edges.
- R5: The word shifted out on `so_d` is `{4'b0000, diag[11:0]}`, most significant bit first. Channel k owns `diag[2k+1:2k]`.
- R6: Command code 4'hA loads `ch_on[5:0]` from frame bits 11:6, with bit 6 going to channel 0. The other data bits have no effect.
- R7: Command code 4'h5 loads `and_mask[5:0]` from frame bits 5:0.
- R8: Command code 4'h3 loads `low_side[2:0]` from frame bits 2:0.
- R9: If a frame has any sample count other than 16 when select rises, it is discarded and no register changes. This includes a 17-bit frame whose last 16 bits form a valid word.
- R10: A complete frame with any other command code changes no register.
- R11: `so_oe` is low while select is high. It rises within a few clock cycles of select falling, and the diagnostic MSB is already on `so_d` at that point, before the first serial clock edge.
- R12: `diag` is captured when select falls. Changes to `diag` during a frame do not alter the word being shifted out.
- R13: Serial clock edges while select is high are ignored. They neither change a register nor disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_sel | input | 1 | Static strap that selects the serial clock edges |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| diag | input | 12 | Diagnostic status, two bits per channel |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for serial data out |
| ch_on | output | 6 | Per-channel on/off bits |
| and_mask | output | 6 | Per-channel combine mode: 1 selects AND, 0 selects OR |
| low_side | output | 3 | Low-side configuration of the last three channels |

## Verification
The hardest case to reach from the ports is a frame that is rejected even though its data looks valid. One such frame runs 17 bits, and its final 16 bits form a legal channel command. A counter that wraps or only checks the low bits would accept it. The bench drives exactly this frame, and also a 15-bit frame, with every data bit set. It then confirms that `ch_on` keeps its earlier value. Separately, the bench switches the strap between frames so that both edge pairings are used. It also toggles the serial clock while select is high, and changes `diag` halfway through a frame.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;
  localparam int unsigned SPS_FRAME_BITS  = 16;
  localparam int unsigned SPS_CMD_BITS    = 4;
  localparam int unsigned SPS_CHANNELS    = 6;
  localparam int unsigned SPS_SIDE_CH     = 3;
  localparam int unsigned SPS_SYNC_STAGES = 2;

  typedef enum logic [SPS_CMD_BITS-1:0] {
    CMD_SIDE = 4'h3,
    CMD_COMB = 4'h5,
    CMD_CHAN = 4'hA
  } sps_cmd_e;
endpackage

// File: rtl/sps_sync.sv
`timescale 1ns/1ps
module sps_sync #(
  parameter int unsigned WIDTH            = 1,
  parameter int unsigned STAGES           = 2,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= RESET_VALUE;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sps_frame.sv
`timescale 1ns/1ps
module sps_frame #(
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic                  in_frame,
  input  logic                  sample_edge,
  input  logic                  shift_edge,
  input  logic                  si_bit,
  input  logic [FRAME_BITS-1:0] tx_word,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  commit,
  output logic                  so_bit
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic                  commit_q, commit_d;
  logic                  rx_en, tx_en;

  // enables: sampling only inside a frame, shifting only after the first sample
  assign rx_en = in_frame && sample_edge;
  assign tx_en = in_frame && shift_edge && (cnt_q != '0);

  always_comb begin
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    commit_d = 1'b0;
    if (frame_start) begin
      cnt_d = '0;
      rx_d  = '0;
      tx_d  = tx_word;
    end else begin
      if (rx_en) begin
        rx_d = {rx_q[FRAME_BITS-2:0], si_bit};
        if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (tx_en) begin
        tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
    if (frame_end && (cnt_q == CNT_FULL)) begin
      commit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      commit_q <= commit_d;
    end
  end

  assign rx_word = rx_q;
  assign commit  = commit_q;
  assign so_bit  = tx_q[FRAME_BITS-1];

  // R2: a new frame starts counting from zero
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt_q == '0));
  // R9: commit only follows a frame that held exactly FRAME_BITS samples
  p_commit_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> ($past(cnt_q) == CNT_FULL) && $past(frame_end));
  // R12: the outgoing word is the diag value seen at frame start
  p_tx_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tx_q == $past(tx_word)));
  // R13: nothing moves in the receive path outside a frame
  p_idle_rx_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !frame_start) |=> $stable(rx_q));
endmodule

// File: rtl/sps_cfg_regs.sv
`timescale 1ns/1ps
module sps_cfg_regs
  import sps_pkg::*;
#(
  parameter int unsigned FRAME_BITS = SPS_FRAME_BITS,
  parameter int unsigned CHANNELS   = SPS_CHANNELS,
  parameter int unsigned SIDE_CH    = SPS_SIDE_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] word,
  output logic [CHANNELS-1:0]   ch_on,
  output logic [CHANNELS-1:0]   and_mask,
  output logic [SIDE_CH-1:0]    low_side
);
  localparam int unsigned CMD_LSB  = FRAME_BITS - SPS_CMD_BITS;
  localparam int unsigned CHAN_LSB = CMD_LSB - CHANNELS;

  logic [SPS_CMD_BITS-1:0] cmd;
  logic [CHANNELS-1:0]     on_q, on_d;
  logic [CHANNELS-1:0]     and_q, and_d;
  logic [SIDE_CH-1:0]      side_q, side_d;
  logic                    on_en, and_en, side_en;

  assign cmd     = word[FRAME_BITS-1:CMD_LSB];
  assign on_en   = commit && (cmd == CMD_CHAN);
  assign and_en  = commit && (cmd == CMD_COMB);
  assign side_en = commit && (cmd == CMD_SIDE);

  always_comb begin
    on_d   = on_q;
    and_d  = and_q;
    side_d = side_q;
    if (on_en)   on_d   = word[CHAN_LSB +: CHANNELS];
    if (and_en)  and_d  = word[CHANNELS-1:0];
    if (side_en) side_d = word[SIDE_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      and_q  <= '0;
      side_q <= '0;
    end else begin
      on_q   <= on_d;
      and_q  <= and_d;
      side_q <= side_d;
    end
  end

  assign ch_on    = on_q;
  assign and_mask = and_q;
  assign low_side = side_q;

  // R9: without a commit pulse no configuration bit moves
  p_hold_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({on_q, and_q, side_q}));
  // R10: unknown codes leave every register alone
  p_unknown_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (cmd != CMD_CHAN) && (cmd != CMD_COMB) && (cmd != CMD_SIDE))
      |=> $stable({on_q, and_q, side_q}));
  // R6: channel command loads the channel field
  p_chan_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (cmd == CMD_CHAN)) |=> (on_q == $past(word[CHAN_LSB +: CHANNELS])));
endmodule

// File: rtl/sps_serial_slave.sv
`timescale 1ns/1ps
module sps_serial_slave
  import sps_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = SPS_FRAME_BITS,
  parameter int unsigned CHANNELS    = SPS_CHANNELS,
  parameter int unsigned SIDE_CH     = SPS_SIDE_CH,
  parameter int unsigned SYNC_STAGES = SPS_SYNC_STAGES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    edge_sel,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    si,
  input  logic [2*CHANNELS-1:0]   diag,
  output logic                    so_d,
  output logic                    so_oe,
  output logic [CHANNELS-1:0]     ch_on,
  output logic [CHANNELS-1:0]     and_mask,
  output logic [SIDE_CH-1:0]      low_side
);
  localparam int unsigned DIAG_W = 2 * CHANNELS;
  localparam int unsigned PAD_W  = FRAME_BITS - DIAG_W;

  logic [1:0] rst_sr_q;
  logic       rst_q_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_q_n = rst_sr_q[1];

  logic [2:0] pins_s;
  logic       cs_s, sclk_s, si_s;

  sps_sync #(
    .WIDTH      (3),
    .STAGES     (SYNC_STAGES),
    .RESET_VALUE(3'b100)
  ) sync_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .async_i({cs_n, sclk, si}),
    .sync_o (pins_s)
  );
  assign {cs_s, sclk_s, si_s} = pins_s;

  logic cs_p_q, sclk_p_q, oe_q;
  logic cs_p_d, sclk_p_d, oe_d;

  assign cs_p_d   = cs_s;
  assign sclk_p_d = sclk_s;
  assign oe_d     = ~cs_s;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cs_p_q   <= 1'b1;
      sclk_p_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      cs_p_q   <= cs_p_d;
      sclk_p_q <= sclk_p_d;
      oe_q     <= oe_d;
    end
  end

  logic sclk_rise, sclk_fall, sample_edge, shift_edge;
  logic frame_start, frame_end, in_frame;

  assign sclk_rise   = sclk_s & ~sclk_p_q;
  assign sclk_fall   = ~sclk_s & sclk_p_q;
  assign sample_edge = edge_sel ? sclk_fall : sclk_rise;
  assign shift_edge  = edge_sel ? sclk_rise : sclk_fall;
  assign frame_start = cs_p_q & ~cs_s;
  assign frame_end   = ~cs_p_q & cs_s;
  assign in_frame    = ~cs_s;

  logic [FRAME_BITS-1:0] tx_word, rx_word;
  logic                  commit;

  generate
    if (PAD_W > 0) begin : g_pad
      assign tx_word = {{PAD_W{1'b0}}, diag};
    end else begin : g_nopad
      assign tx_word = diag[FRAME_BITS-1:0];
    end
  endgenerate

  sps_frame #(
    .FRAME_BITS(FRAME_BITS)
  ) frame_i (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .in_frame   (in_frame),
    .sample_edge(sample_edge),
    .shift_edge (shift_edge),
    .si_bit     (si_s),
    .tx_word    (tx_word),
    .rx_word    (rx_word),
    .commit     (commit),
    .so_bit     (so_d)
  );

  sps_cfg_regs #(
    .FRAME_BITS(FRAME_BITS),
    .CHANNELS  (CHANNELS),
    .SIDE_CH   (SIDE_CH)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .commit  (commit),
    .word    (rx_word),
    .ch_on   (ch_on),
    .and_mask(and_mask),
    .low_side(low_side)
  );

  assign so_oe = oe_q;

  // R11: output is released the cycle after select is seen high
  p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_end |=> !so_oe);
  // R11: output drives once select is seen low
  p_oe_on_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    frame_start |=> so_oe);
  // R2: commit never happens while a frame is still open
  p_commit_closed_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    commit |-> cs_p_q);
endmodule

// File: tb/sps_serial_slave_tb.sv
`timescale 1ns/1ps
module sps_serial_slave_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        edge_sel;
  logic        cs_n;
  logic        sclk;
  logic        si;
  logic [11:0] diag;
  logic        so_d;
  logic        so_oe;
  logic [5:0]  ch_on;
  logic [5:0]  and_mask;
  logic [2:0]  low_side;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  logic oe_mid;
  logic [5:0] exp_on, exp_and;
  logic [2:0] exp_side;

  always #4 clk = ~clk;

  sps_serial_slave dut_i (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .cs_n(cs_n), .sclk(sclk),
    .si(si), .diag(diag), .so_d(so_d), .so_oe(so_oe), .ch_on(ch_on),
    .and_mask(and_mask), .low_side(low_side)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hc();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    check(req, {26'd0, ch_on}, {26'd0, exp_on});
    check(req, {26'd0, and_mask}, {26'd0, exp_and});
    check(req, {29'd0, low_side}, {29'd0, exp_side});
  endtask

  task automatic set_mode(input logic m);
    edge_sel = m;
    sclk = m;
    hc();
  endtask

  task automatic xfer(input logic [31:0] word, input int nbits, input int swap_at,
                      input logic [11:0] swap_val, output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    hc();
    oe_mid = so_oe;
    for (int i = nbits - 1; i >= 0; i--) begin
      si = word[i];
      if ((nbits - 1 - i) == swap_at) diag = swap_val;
      hc();
      got = {got[30:0], so_d};
      sclk = ~edge_sel;
      hc();
      sclk = edge_sel;
    end
    hc();
    cs_n = 1'b1;
    hc();
  endtask

  task automatic t_reset();
    check("R1 ch_on", {26'd0, ch_on}, 32'd0);
    check("R1 and_mask", {26'd0, and_mask}, 32'd0);
    check("R1 low_side", {29'd0, low_side}, 32'd0);
    check("R1 so_oe", {31'd0, so_oe}, 32'd0);
  endtask

  task automatic t_chan_rise();
    logic [31:0] got;
    set_mode(1'b0);
    diag = 12'hA5C;
    xfer({16'd0, 4'hA, 6'b101101, 6'b000000}, 16, -1, 12'h0, got);
    exp_on = 6'b101101;
    check_regs("R6 R3 R2 channel load, rising sample");
    check("R5 R3 diag out", got, {16'd0, 4'h0, 12'hA5C});
    check("R11 oe during frame", {31'd0, oe_mid}, 32'd1);
    check("R11 oe after frame", {31'd0, so_oe}, 32'd0);
  endtask

  task automatic t_chan_fall();
    logic [31:0] got;
    set_mode(1'b1);
    diag = 12'h3C9;
    xfer({16'd0, 4'hA, 6'b010011, 6'b111111}, 16, -1, 12'h0, got);
    exp_on = 6'b010011;
    check_regs("R4 R6 channel load, falling sample");
    check("R4 R5 diag out", got, {16'd0, 4'h0, 12'h3C9});
  endtask

  task automatic t_comb();
    logic [31:0] got;
    xfer({16'd0, 4'h5, 6'b111111, 6'b110010}, 16, -1, 12'h0, got);
    exp_and = 6'b110010;
    check_regs("R7 combine mask");
  endtask

  task automatic t_side();
    logic [31:0] got;
    set_mode(1'b0);
    xfer({16'd0, 4'h3, 9'h1FF, 3'b101}, 16, -1, 12'h0, got);
    exp_side = 3'b101;
    check_regs("R8 low side");
  endtask

  task automatic t_bad_length();
    logic [31:0] got;
    xfer({17'd0, 15'h7FFF}, 15, -1, 12'h0, got);
    check_regs("R9 short frame");
    xfer({15'd0, 1'b1, 16'hAFC0}, 17, -1, 12'h0, got);
    check_regs("R9 long frame");
  endtask

  task automatic t_unknown();
    logic [31:0] got;
    xfer({16'd0, 4'h7, 12'hFFF}, 16, -1, 12'h0, got);
    check_regs("R10 unknown code");
    xfer({16'd0, 4'h0, 12'hFFF}, 16, -1, 12'h0, got);
    check_regs("R10 zero code");
  endtask

  task automatic t_diag_swap();
    logic [31:0] got;
    set_mode(1'b1);
    diag = 12'h111;
    xfer({16'd0, 4'h5, 6'd0, 6'b000111}, 16, 5, 12'hEEE, got);
    exp_and = 6'b000111;
    check("R12 diag frozen", got, {16'd0, 4'h0, 12'h111});
    check_regs("R12 frame still applied");
  endtask

  task automatic t_idle_edges();
    logic [31:0] got;
    set_mode(1'b0);
    si = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk;
      hc();
    end
    sclk = 1'b0;
    hc();
    check_regs("R13 idle edges");
    diag = 12'h5A3;
    xfer({16'd0, 4'hA, 6'b110001, 6'b000000}, 16, -1, 12'h0, got);
    exp_on = 6'b110001;
    check_regs("R13 R2 frame after idle edges");
    check("R13 diag after idle edges", got, {16'd0, 4'h0, 12'h5A3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    edge_sel = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    si = 1'b0;
    diag = 12'h000;
    exp_on = '0;
    exp_and = '0;
    exp_side = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_chan_rise();
    t_chan_fall();
    t_comb();
    t_side();
    t_bad_length();
    t_unknown();
    t_diag_swap();
    t_idle_edges();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule